// File: doc/BRIEF.md
# DMA Global Enable and Halt Control

This block is the shared control point for a five-channel DMA controller. It holds one control byte containing a master enable, a priority-mode flag and a four-bit halt code, and it sits between the per-channel start, completion and request signals and the channel transfer engines. The engines see only gated signals: a per-channel run flag, a permission to begin the next block, and the peripheral transfer requests masked by the run and enable state.

Software reaches the control byte through byte-wide accesses, selected by a two-bit lane number. Only lane 3 holds state; the other three lanes read as zero and ignore writes. Setting the master enable only allows channels to be started. Each channel still needs its own start pulse.

Clearing the master enable takes effect gracefully. Request forwarding is cut at once. A running channel keeps its run flag until its engine reports the end of the current block, then drops it. Start pulses that arrive while the enable is clear are discarded, not held for later. A nonzero halt code pauses new block starts on every channel and leaves the master enable unchanged. There is no data stream through the block, so every pin is a plain level or pulse.

Top module: `dmag_global_ctl`

## Requirements
- R1: After reset the control byte reads 0x00, every `ch_run`, `ch_blk_go` and `ch_req_out` bit is 0, and `dma_on` and `prio_mode` are 0.
- R2: A write with `cfg_wr_lane` = 3 updates the control byte on the next clock edge. Bit 7 is the master enable, bit 4 is the priority mode and bits 3:0 are the halt code. Bits 6 and 5 always read 0. `cfg_rd_byte` returns the byte for `cfg_rd_lane` in the same cycle.
- R3: Lanes 0, 1 and 2 always read 0x00. Writes to those lanes leave the control byte unchanged.
- R4: A `ch_start` pulse while the enable is set raises that channel's `ch_run` one cycle later. Setting the enable by itself raises no `ch_run` bit.
- R5: A `ch_start` pulse while the enable is clear is discarded. `ch_run` stays 0, and it stays 0 after a later enable.
- R6: A `ch_done` pulse without a simultaneous accepted start clears that channel's `ch_run` one cycle later. A start accepted in the same cycle wins and keeps the channel running.
- R7: While the enable is clear, a running channel keeps `ch_run` high until its `ch_blk_end` pulse, and `ch_run` is low from the following cycle.
- R8: `ch_req_out[i]` equals `ch_req_in[i]` AND `ch_run[i]` AND the enable, combinationally. It falls in the first cycle in which the enable reads clear.
- R9: `ch_blk_go[i]` is high exactly when `ch_run[i]` is high, the enable is set and the halt code is zero. Writing a nonzero halt code changes neither `dma_on` nor any `ch_run` bit.
- R10: `dma_on` and `prio_mode` follow control bits 7 and 4.
- R11: A `ch_blk_end` pulse while the enable is set has no effect on `ch_run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Byte write strobe |
| cfg_wr_lane | input | 2 | Byte lane written |
| cfg_wr_byte | input | 8 | Write data |
| cfg_rd_lane | input | 2 | Byte lane read |
| cfg_rd_byte | output | 8 | Read data for the selected lane |
| ch_start | input | 5 | Per-channel start pulses |
| ch_done | input | 5 | Per-channel transfer-complete pulses |
| ch_blk_end | input | 5 | Per-channel block-boundary pulses |
| ch_req_in | input | 5 | Peripheral transfer requests |
| ch_run | output | 5 | Channel running flags |
| ch_blk_go | output | 5 | Permission to begin the next block |
| ch_req_out | output | 5 | Gated transfer requests |
| dma_on | output | 1 | Master enable state |
| prio_mode | output | 1 | Priority mode bit for the arbiter |

## Verification
The assertions watch, on every cycle, that a write to the control lane lands on the next edge and that the idle lanes read zero. They also check that an idle channel cannot start while disabled, that a disabled running channel holds until its boundary pulse, that a done pulse ends a run, and that block permission never appears without a run. Only the bench scenarios can show the timing of an enable followed by a start, that a discarded start stays discarded after a later enable, that halt codes leave the run flags alone, and how the outputs behave when writes, starts, completions and boundaries overlap under random traffic.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  localparam int unsigned LANE_W   = 2;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned HALT_W   = 4;
  localparam int unsigned CTL_LANE = 3;
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned PRIO_BIT = 4;

  typedef struct packed {
    logic              en;
    logic              prio;
    logic [HALT_W-1:0] halt;
  } gcfg_t;

  function automatic logic [BYTE_W-1:0] pack_cfg(input gcfg_t c);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[EN_BIT]       = c.en;
    b[PRIO_BIT]     = c.prio;
    b[HALT_W-1:0]   = c.halt;
    return b;
  endfunction
endpackage

// File: rtl/dmag_ctrl_reg.sv
module dmag_ctrl_reg
  import dmag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [LANE_W-1:0] rd_lane,
  output logic [BYTE_W-1:0] rd_byte,
  output gcfg_t             cfg
);
  localparam logic [LANE_W-1:0] CTL_SEL = LANE_W'(CTL_LANE);

  gcfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en && wr_lane == CTL_SEL) begin
      cfg_q.en   <= wr_byte[EN_BIT];
      cfg_q.prio <= wr_byte[PRIO_BIT];
      cfg_q.halt <= wr_byte[HALT_W-1:0];
    end
  end

  always_comb begin
    rd_byte = '0;
    if (rd_lane == CTL_SEL) rd_byte = pack_cfg(cfg_q);
  end

  assign cfg = cfg_q;

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lane == CTL_SEL) |=>
      (cfg_q.en == $past(wr_byte[EN_BIT]) && cfg_q.halt == $past(wr_byte[HALT_W-1:0])));

  assert_other_lane_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_lane == CTL_SEL) |=> $stable(cfg_q));

  assert_idle_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lane != CTL_SEL) |-> (rd_byte == '0));
endmodule

// File: rtl/dmag_chan_gate.sv
module dmag_chan_gate
  import dmag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [HALT_W-1:0] halt,
  input  logic              start,
  input  logic              done,
  input  logic              blk_end,
  input  logic              req_in,
  output logic              run,
  output logic              blk_go,
  output logic              req_out
);
  logic run_q, run_d, start_ok, stop_at_bnd;

  always_comb begin
    start_ok    = start & en;
    stop_at_bnd = run_q & ~en & blk_end;
    run_d       = run_q;
    if (done || stop_at_bnd) run_d = 1'b0;
    if (start_ok)            run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign run     = run_q;
  assign blk_go  = run_q & en & (halt == '0);
  assign req_out = req_in & run_q & en;

  assert_no_start_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !run_q) |=> !run_q);

  assert_hold_until_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !en && !blk_end && !done) |=> run_q);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !run_q);

  assert_start_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && en) |=> run_q);

  assert_go_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blk_go |-> (run && halt == '0));
endmodule

// File: rtl/dmag_global_ctl.sv
module dmag_global_ctl
  import dmag_pkg::*;
#(
  parameter int unsigned NUM_CH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_wr_lane,
  input  logic [7:0]        cfg_wr_byte,
  input  logic [1:0]        cfg_rd_lane,
  output logic [7:0]        cfg_rd_byte,
  input  logic [NUM_CH-1:0] ch_start,
  input  logic [NUM_CH-1:0] ch_done,
  input  logic [NUM_CH-1:0] ch_blk_end,
  input  logic [NUM_CH-1:0] ch_req_in,
  output logic [NUM_CH-1:0] ch_run,
  output logic [NUM_CH-1:0] ch_blk_go,
  output logic [NUM_CH-1:0] ch_req_out,
  output logic              dma_on,
  output logic              prio_mode
);
  gcfg_t cfg;

  dmag_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_lane (cfg_wr_lane),
    .wr_byte (cfg_wr_byte),
    .rd_lane (cfg_rd_lane),
    .rd_byte (cfg_rd_byte),
    .cfg     (cfg)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dmag_chan_gate u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cfg.en),
      .halt    (cfg.halt),
      .start   (ch_start[i]),
      .done    (ch_done[i]),
      .blk_end (ch_blk_end[i]),
      .req_in  (ch_req_in[i]),
      .run     (ch_run[i]),
      .blk_go  (ch_blk_go[i]),
      .req_out (ch_req_out[i])
    );
  end

  assign dma_on    = cfg.en;
  assign prio_mode = cfg.prio;

  assert_req_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_on |-> (ch_req_out == '0 && ch_blk_go == '0));

  assert_en_only_no_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start == '0 && ch_run == '0) |=> (ch_run == '0));
endmodule

// File: tb/sim_dmag_global_ctl.sv
module sim_dmag_global_ctl;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_lane = '0;
  logic [7:0] cfg_wr_byte = '0;
  logic [1:0] cfg_rd_lane = '0;
  logic [7:0] cfg_rd_byte;
  logic [N-1:0] ch_start = '0, ch_done = '0, ch_blk_end = '0, ch_req_in = '0;
  logic [N-1:0] ch_run, ch_blk_go, ch_req_out;
  logic dma_on, prio_mode;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // reference model state
  bit m_en, m_prio;
  bit [3:0] m_halt;
  bit [N-1:0] m_run;

  always #10 clk = ~clk;

  dmag_global_ctl u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_lane(cfg_wr_lane), .cfg_wr_byte(cfg_wr_byte),
    .cfg_rd_lane(cfg_rd_lane), .cfg_rd_byte(cfg_rd_byte),
    .ch_start(ch_start), .ch_done(ch_done), .ch_blk_end(ch_blk_end),
    .ch_req_in(ch_req_in), .ch_run(ch_run), .ch_blk_go(ch_blk_go),
    .ch_req_out(ch_req_out), .dma_on(dma_on), .prio_mode(prio_mode)
  );

  function automatic bit [7:0] exp_rd(input bit [1:0] lane);
    return (lane == 2'd3) ? {m_en, 2'b00, m_prio, m_halt} : 8'h00;
  endfunction

  function automatic bit [N-1:0] exp_go();
    return (m_en && m_halt == 4'd0) ? m_run : '0;
  endfunction

  function automatic bit [N-1:0] exp_req(input bit [N-1:0] rin);
    return m_en ? (rin & m_run) : '0;
  endfunction

  function automatic bit [N-1:0] next_run(input bit [N-1:0] st, input bit [N-1:0] dn,
                                          input bit [N-1:0] be);
    bit [N-1:0] keep;
    keep = m_run & ~dn & ~(m_en ? '0 : be);
    return keep | (m_en ? st : '0);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R2/R3 cfg_rd_byte", cfg_rd_byte, exp_rd(cfg_rd_lane));
    check("R4/R5/R6/R7/R11 ch_run", ch_run, m_run);
    check("R9 ch_blk_go", ch_blk_go, exp_go());
    check("R8 ch_req_out", ch_req_out, exp_req(ch_req_in));
    check("R10 dma_on", dma_on, m_en);
    check("R10 prio_mode", prio_mode, m_prio);
  endtask

  // drive one cycle of stimulus, check, then advance the model at the edge
  task automatic step(input bit we, input bit [1:0] wl, input bit [7:0] wb, input bit [1:0] rl,
                      input bit [N-1:0] st, input bit [N-1:0] dn, input bit [N-1:0] be,
                      input bit [N-1:0] rq);
    bit [N-1:0] nr;
    @(negedge clk);
    cfg_wr_en = we; cfg_wr_lane = wl; cfg_wr_byte = wb; cfg_rd_lane = rl;
    ch_start = st; ch_done = dn; ch_blk_end = be; ch_req_in = rq;
    #1;
    check_all();
    nr = next_run(st, dn, be);
    @(posedge clk);
    m_run = nr;
    if (we && wl == 2'd3) begin
      m_en = wb[7]; m_prio = wb[4]; m_halt = wb[3:0];
    end
  endtask

  task automatic idle(input bit [1:0] rl);
    step(0, 0, 0, rl, '0, '0, '0, '1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_en = 0; m_prio = 0; m_halt = 0; m_run = '0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1'b1;
    // R1: reset state
    @(negedge clk); cfg_rd_lane = 2'd3; #1;
    check("R1 reset byte", cfg_rd_byte, 0);
    check("R1 reset run", ch_run, 0);
    check("R1 reset go", ch_blk_go | ch_req_out, 0);
    // R5: start while disabled is dropped, stays dropped after enable
    step(0, 0, 0, 3, 5'b00101, '0, '0, '1);
    idle(3);
    step(1, 3, 8'h80, 3, '0, '0, '0, '1);
    idle(3);
    check("R5 discarded start", ch_run, 0);
    // R4: enable alone starts nothing; start then runs
    check("R4 enable alone", ch_run, 0);
    step(0, 0, 0, 3, 5'b00011, '0, '0, '1);
    idle(3);
    check("R4 started", ch_run, 5'b00011);
    // R11: boundary while enabled
    step(0, 0, 0, 3, '0, '0, 5'b11111, '1);
    idle(3);
    check("R11 boundary enabled", ch_run, 5'b00011);
    // R9: halt code gates blk_go, leaves enable and run
    step(1, 3, 8'h85, 3, '0, '0, '0, '1);
    idle(3);
    check("R9 halt go", ch_blk_go, 0);
    check("R9 halt keeps enable", dma_on, 1);
    check("R9 halt keeps run", ch_run, 5'b00011);
    // R3: writes to other lanes ignored
    step(1, 0, 8'h00, 3, '0, '0, '0, '1);
    step(1, 2, 8'h00, 3, '0, '0, '0, '1);
    idle(1);
    check("R3 lane write ignored", dma_on, 1);
    // R7: disable while running waits for the boundary
    step(1, 3, 8'h10, 3, '0, '0, '0, '1);
    idle(3); idle(3);
    check("R7 hold until boundary", ch_run, 5'b00011);
    check("R8 req dropped", ch_req_out, 0);
    step(0, 0, 0, 3, '0, '0, 5'b00001, '1);
    idle(3);
    check("R7 stopped at boundary", ch_run, 5'b00010);
    // R6: done ends run
    step(1, 3, 8'h80, 3, '0, '0, '0, '1);
    step(0, 0, 0, 3, '0, 5'b00010, '0, '1);
    idle(3);
    check("R6 done clears", ch_run, 0);
    // R6: start and done together keep running
    step(0, 0, 0, 3, 5'b00100, 5'b00100, '0, '1);
    idle(3);
    check("R6 start wins over done", ch_run, 5'b00100);
    // constrained random traffic
    for (int k = 0; k < 3000; k++) begin
      bit we;
      bit [7:0] wb;
      bit [N-1:0] st, dn, be;
      we = ($urandom_range(0, 15) == 0);
      wb = 8'($urandom());
      if ($urandom_range(0, 2) != 0) wb[3:0] = 4'd0;
      st = N'($urandom()) & N'($urandom());
      dn = N'($urandom()) & N'($urandom()) & N'($urandom());
      be = N'($urandom()) & N'($urandom());
      step(we, 2'($urandom()), wb, 2'($urandom()), st, dn, be, N'($urandom()));
    end
    idle(3);
    finished = 1;
    finish_run();
  end
endmodule